// File: doc/BRIEF.md
# Looping User Pattern Playback Engine

This block replays a stored bit pattern without end for a pair of output channels. Each channel has its own pattern memory, built from 512-bit words and loaded through a simple write port while playback is off. One sequencer serves both channels. It walks a single read address over the first `pat_len` words, wraps to word 0 after the last word, and fetches the same word index for both channels at once. Both patterns therefore always have the same length and reach the end of the pattern in the same cycle.

Each fetched word goes first into a shadow register. It then moves into a serializing shift register, which sends it least significant bit first as 4-bit output words. A word boundary does not cost a cycle, and the end of the pattern does not either. A rate setting repeats every pattern bit 2 or 4 times, so a word lasts 128, 256 or 512 clocks. Each channel can complement its own output. `frame_out` marks the output word that carries bit 0 of the pattern. The outputs are held at zero after reset. They stay at zero until `enable` is raised with a valid length.

Length, rate and invert are changed only while `enable` is low. Memory writes are also made only while `enable` is low.

Top module: `upat_player`

## Requirements
- R1: Let L be the pattern length in words and R the repeat factor. Let k count output cycles, with k = 0 at the cycle where `frame_out` is high. Then bit j of channel c's output word (`data_out[c*4+j]`) equals pattern bit p = floor((4k+j)/R) mod (512*L). Pattern bit p is bit (p mod 512) of memory word floor(p/512) of channel c.
- R2: Playback wraps from the last bit of word L-1 to bit 0 of word 0 with no extra cycle and no repeated or dropped bit. Word boundaries inside the pattern also cost no cycle.
- R3: `frame_out` is high exactly on the output cycles where 4k mod (512*L*R) = 0. It is low on every other cycle.
- R4: `rate_sel` 00 selects R = 1, 01 selects R = 2, and 10 or 11 selects R = 4. Each pattern bit occupies R consecutive output bit positions.
- R5: When `invert[c]` is 1, channel c outputs the complement of its R1 value. The other channel is unaffected.
- R6: After reset, and whenever `enable` has been sampled low at a rising edge, `data_out` and `frame_out` are 0 from the next rising edge on.
- R7: With `pat_len` = 0 or `pat_len` greater than DEPTH, `data_out` and `frame_out` stay 0 even with `enable` high.
- R8: Suppose `enable` is first sampled high, with a valid length, at a rising edge. Then `data_out` stays 0 until the fourth rising edge after that edge. Right after that fourth edge, `frame_out` is 1 and output word k = 0 is present.
- R9: A word written with `wr_en`, `wr_ch`, `wr_addr` and `wr_data` while playback is off is the word the next playback emits for that channel and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Turns playback on; outputs stay 0 while low |
| pat_len | input | ADDR_W+1 | Pattern length in 512-bit words; valid range 1..DEPTH |
| rate_sel | input | 2 | Bit repeat factor: 00 gives 1, 01 gives 2, 1x gives 4 |
| invert | input | NCH | Per-channel output complement |
| wr_en | input | 1 | Memory write strobe |
| wr_ch | input | CH_W | Channel whose memory is written |
| wr_addr | input | ADDR_W | Word index written |
| wr_data | input | WORD_W | Word written, bit 0 sent first |
| data_out | output | NCH*OUT_W | Channel c occupies bits [c*OUT_W +: OUT_W]; bit 0 is the earliest |
| frame_out | output | 1 | High on the output word holding pattern bit 0 |

## Verification
The bench sweeps every length from 1 to 4 words against all four rate codes. Each run covers two full pattern repetitions and compares every output word with the R1 formula. The one-word length wraps at every word, so it separates seamless wrapping from ordinary word turnover. The longer lengths expose an address that wraps early or late. The aliased rate code 11 is checked against code 10. The invert mask is rotated across the sweep, so a mix-up between channels shows up as a miscompare on one channel only. The two channels are filled with unrelated words, so a swapped or stale shadow word would also show. Lengths 0 and DEPTH+1 are applied with `enable` high and must give a silent output. A second load of fresh content confirms that playback follows newly written memory.

// File: rtl/upat_pkg.sv
package upat_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH0,
    PH_FETCH1,
    PH_LOAD,
    PH_RUN
  } phase_t;

  // log2 of the bit repeat factor selected by the rate code
  function automatic logic [1:0] rep_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/upat_ram.sv
module upat_ram #(
  parameter int WORD_W = 512,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/upat_seq.sv
module upat_seq
  import upat_pkg::*;
#(
  parameter int WORD_W = 512,
  parameter int OUT_W  = 4,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = ADDR_W + 1,
  localparam int BEATS  = WORD_W / OUT_W,
  localparam int BEAT_W = $clog2(BEATS * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LEN_W-1:0]  pat_len,
  input  logic [1:0]        rsh,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fill,
  output logic              load,
  output logic              shift,
  output logic              stream,
  output logic              beat0,
  output logic              len_ok,
  output logic              frame_out
);

  phase_t            ph;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] beat_max;
  logic              at_last;
  logic              go;
  logic              fill_q;
  logic              tag_first;
  logic              sh_first;
  logic              cur_first;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [LEN_W-1:0]  len);
    if ({1'b0, a} == len - LEN_W'(1)) return '0;
    return a + ADDR_W'(1);
  endfunction

  assign len_ok   = (pat_len != '0) && (pat_len <= LEN_W'(DEPTH));
  assign go       = enable && len_ok;
  assign beat_max = BEAT_W'((BEATS << rsh) - 1);
  assign at_last  = (ph == PH_RUN) && (beat == beat_max);
  assign rd_en    = go && ((ph == PH_FETCH0) || (ph == PH_FETCH1) || at_last);
  assign rd_addr  = '0 | rd_addr_q;
  assign stream   = (ph == PH_RUN);
  assign load     = go && ((ph == PH_LOAD) || at_last);
  assign shift    = go && (ph == PH_RUN) && !at_last;
  assign fill     = fill_q;
  assign beat0    = stream && (beat == '0);

  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      beat      <= '0;
      rd_addr_q <= '0;
      fill_q    <= 1'b0;
      tag_first <= 1'b0;
      sh_first  <= 1'b0;
      cur_first <= 1'b0;
      frame_out <= 1'b0;
    end else begin
      fill_q    <= rd_en;
      tag_first <= (rd_addr_q == '0);
      if (fill_q) sh_first <= tag_first;
      frame_out <= stream && (beat == '0) && cur_first;
      if (!go) begin
        ph        <= PH_IDLE;
        beat      <= '0;
        rd_addr_q <= '0;
      end else begin
        if (rd_en) rd_addr_q <= step_addr(rd_addr_q, pat_len);
        case (ph)
          PH_IDLE:   ph <= PH_FETCH0;
          PH_FETCH0: ph <= PH_FETCH1;
          PH_FETCH1: ph <= PH_LOAD;
          PH_LOAD: begin
            ph        <= PH_RUN;
            beat      <= '0;
            cur_first <= sh_first;
          end
          PH_RUN: begin
            if (at_last) begin
              beat      <= '0;
              cur_first <= sh_first;
            end else begin
              beat <= beat + BEAT_W'(1);
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/upat_lane.sv
module upat_lane #(
  parameter int WORD_W = 512,
  parameter int OUT_W  = 4,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(OUT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              fill,
  input  logic              load,
  input  logic              shift,
  input  logic              stream,
  input  logic [1:0]        rsh,
  input  logic              invert,
  output logic [OUT_W-1:0]  dout
);

  logic [WORD_W-1:0] rdata;
  logic [WORD_W-1:0] shadow;
  logic [WORD_W-1:0] sh;
  logic [OUT_W-1:0]  sh_low;
  logic [OUT_W-1:0]  spread;

  upat_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  assign sh_low = sh[OUT_W-1:0];

  // each output position j carries pattern bit j >> rsh of the current beat
  always_comb begin
    for (int j = 0; j < OUT_W; j++) begin
      spread[j] = sh_low[IDX_W'(j) >> rsh];
    end
  end

  always_ff @(posedge clk) begin
    if (fill) shadow <= rdata;
    if (load)       sh <= shadow;
    else if (shift) sh <= sh >> (OUT_W >> rsh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '0;
    else        dout <= stream ? (spread ^ {OUT_W{invert}}) : '0;
  end

endmodule

// File: rtl/upat_player.sv
module upat_player
  import upat_pkg::*;
#(
  parameter int WORD_W = 512,
  parameter int OUT_W  = 4,
  parameter int NCH    = 2,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = ADDR_W + 1,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [LEN_W-1:0]     pat_len,
  input  logic [1:0]           rate_sel,
  input  logic [NCH-1:0]       invert,
  input  logic                 wr_en,
  input  logic [CH_W-1:0]      wr_ch,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [NCH*OUT_W-1:0] data_out,
  output logic                 frame_out
);

  logic [1:0]        rsh;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              fill;
  logic              load;
  logic              shift;
  logic              stream;
  logic              beat0;
  logic              len_ok;

  assign rsh = rep_shift(rate_sel);

  upat_seq #(.WORD_W(WORD_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pat_len   (pat_len),
    .rsh       (rsh),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .fill      (fill),
    .load      (load),
    .shift     (shift),
    .stream    (stream),
    .beat0     (beat0),
    .len_ok    (len_ok),
    .frame_out (frame_out)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    upat_lane #(.WORD_W(WORD_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && (wr_ch == CH_W'(c))),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .fill    (fill),
      .load    (load),
      .shift   (shift),
      .stream  (stream),
      .rsh     (rsh),
      .invert  (invert[c]),
      .dout    (data_out[c*OUT_W +: OUT_W])
    );
  end

endmodule

// File: rtl/upat_player_chk.sv
module upat_player_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          frame_out,
  input logic          stream,
  input logic          fill,
  input logic          beat0,
  input logic          len_ok,
  input logic [DW-1:0] data_out
);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stream |=> (data_out == '0) && !frame_out);

  // R6
  enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !stream);

  // R7
  bad_len_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !len_ok |=> !stream);

  // R3
  frame_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_out |-> $past(beat0));

  // R2
  prefetch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream) |-> $past(fill));

  // R2
  refill_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stream && fill) |-> beat0);

endmodule

bind upat_player upat_player_chk #(.DW(NCH*OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .frame_out (frame_out),
  .stream    (stream),
  .fill      (fill),
  .beat0     (beat0),
  .len_ok    (len_ok),
  .data_out  (data_out)
);

// File: tb/upat_player_test.sv
module upat_player_test;

  localparam int W   = 512;
  localparam int OW  = 4;
  localparam int NC  = 2;
  localparam int DEP = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           enable;
  logic [2:0]     pat_len;
  logic [1:0]     rate_sel;
  logic [NC-1:0]  invert;
  logic           wr_en;
  logic           wr_ch;
  logic [1:0]     wr_addr;
  logic [W-1:0]   wr_data;
  logic [NC*OW-1:0] data_out;
  logic           frame_out;

  logic [W-1:0] bmem [NC][DEP];
  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  upat_player #(.WORD_W(W), .OUT_W(OW), .NCH(NC), .DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pat_len(pat_len),
    .rate_sel(rate_sel), .invert(invert), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_addr(wr_addr), .wr_data(wr_data), .data_out(data_out),
    .frame_out(frame_out)
  );

  task automatic note(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gen_word(input int ch, input int wd, input int salt);
    logic [W-1:0] w;
    logic [31:0] x;
    for (int i = 0; i < W / 32; i++) begin
      x = (32'(ch + 1) * 32'h9E3779B9) ^ (32'(wd + 1) * 32'h85EBCA6B)
        ^ (32'(i + 1) * 32'hC2B2AE35) ^ 32'(salt);
      x = x ^ (x >> 15);
      x = x * 32'h2C1B3C6D;
      x = x ^ (x >> 13);
      w[i*32 +: 32] = x;
    end
    return w;
  endfunction

  task automatic load_mem(input int salt);
    for (int ch = 0; ch < NC; ch++) begin
      for (int wd = 0; wd < DEP; wd++) begin
        bmem[ch][wd] = gen_word(ch, wd, salt);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = ch[0]; wr_addr = wd[1:0]; wr_data = bmem[ch][wd];
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [OW-1:0] exp_word(input int ch, input int len, input int rep,
                                             input int k, input bit inv);
    logic [OW-1:0] v;
    for (int j = 0; j < OW; j++) begin
      int p;
      p = ((k * OW + j) / rep) % (len * W);
      v[j] = bmem[ch][p / W][p % W] ^ inv;
    end
    return v;
  endfunction

  task automatic run_case(input int len, input int rs, input int inv, input string tag);
    int rep, period, n;
    bit pre_ok;
    rep = (rs == 0) ? 1 : (rs == 1) ? 2 : 4;
    period = len * (W / OW) * rep;
    @(negedge clk);
    pat_len = len[2:0]; rate_sel = rs[1:0]; invert = inv[NC-1:0]; enable = 1'b1;
    n = 0; pre_ok = 1'b1;
    while (n < 12) begin
      @(negedge clk);
      n++;
      if (frame_out) break;
      if (data_out != '0) pre_ok = 1'b0;
    end
    note(n == 5, "R8", "cycles to first frame", n, 5);
    note(pre_ok, "R8", "output quiet before first frame", pre_ok, 1);
    for (int k = 0; k < 2 * period; k++) begin
      if (k != 0) @(negedge clk);
      for (int ch = 0; ch < NC; ch++) begin
        logic [OW-1:0] e;
        logic [OW-1:0] a;
        string lab;
        bit ib;
        ib = inv[ch];
        e = exp_word(ch, len, rep, k, ib);
        a = data_out[ch*OW +: OW];
        if (tag != "")                        lab = tag;
        else if ((k % period == 0) && k > 0) lab = "R2";
        else if (ib)                          lab = "R5";
        else if (rep > 1)                     lab = "R4";
        else                                  lab = "R1";
        note(a == e, lab, $sformatf("ch%0d len %0d rate %0d k %0d", ch, len, rs, k), a, e);
      end
      note(frame_out == (k % period == 0), "R3",
           $sformatf("frame len %0d rate %0d k %0d", len, rs, k),
           frame_out, (k % period == 0));
    end
    enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      note(data_out == '0 && !frame_out, "R6", "output after disable",
           {frame_out, data_out}, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; pat_len = '0; rate_sel = '0; invert = '0;
    wr_en = 1'b0; wr_ch = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    note(data_out == '0 && !frame_out, "R6", "output in reset", {frame_out, data_out}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      note(data_out == '0 && !frame_out, "R6", "output after reset", {frame_out, data_out}, 0);
    end

    load_mem(32'h1234);

    // R7: invalid lengths keep the outputs silent
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      pat_len = (b == 0) ? 3'd0 : 3'd5; rate_sel = 2'b00; invert = 2'b11; enable = 1'b1;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        note(data_out == '0 && !frame_out, "R7", $sformatf("len %0d output", pat_len),
             {frame_out, data_out}, 0);
      end
      enable = 1'b0;
      repeat (3) @(negedge clk);
    end

    for (int len = 1; len <= DEP; len++) begin
      for (int rs = 0; rs < 4; rs++) begin
        run_case(len, rs, (len + rs) % 4, "");
      end
    end

    // R9: fresh content written while idle is played back
    load_mem(32'h5A5A0F0F);
    run_case(3, 0, 0, "R9");
    run_case(4, 1, 1, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule